// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Enable Register

This block keeps the sticky event flags of an I2C controller and decides which of them drive the interrupt line. Seven event sources arrive as one-cycle pulses from the rest of the controller: no-acknowledge, arbitration lost, transfer done (register access ready), transmit ready, transmit draining, receive ready and receive draining. Each pulse latches its flag until software acknowledges it by writing a one to that status bit.

Software reaches the block through a 16-bit register port with four word addresses. It can read the flags raw or masked by the enables, and it changes the enables through separate set and clear addresses, so it never needs a read-modify-write. The live bus-busy level shows in the raw view only and is never latched. The interrupt output is a registered OR of all flags that are both pending and enabled.

Top module: `i2c_irq_status_regs`

## Requirements
- R1: After reset all flags and all enables are 0, the interrupt output is low, and reads at every address return 0 while bus busy is low.
- R2: A pulse on event input bit i sets flag i at the next clock edge, and the flag stays set with no further pulse. Flag bits are: 0 no-acknowledge, 1 arbitration lost, 2 transfer done, 3 transmit ready, 4 transmit draining, 5 receive ready, 6 receive draining.
- R3: A write to address 0 (raw) or address 1 (masked) clears each flag whose data bit is 1; flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same flag in the same cycle, the flag is set after that edge.
- R5: A write to address 2 sets each enable whose data bit is 1 and leaves the rest; reads at address 2 and address 3 return the enables in bits 6:0 and 0 above.
- R6: A write to address 3 clears each enable whose data bit is 1 and leaves the rest.
- R7: A read at address 0 returns the flags in bits 6:0 regardless of the enables, and in bit 12 the current bus-busy input level; other bits read 0.
- R8: A read at address 1 returns the flags ANDed with the enables in bits 6:0; bit 12 and all other bits read 0.
- R9: The interrupt output is high in a cycle exactly when, in the previous cycle, at least one flag and its enable were both 1.
- R10: Writing 0xFFFF to address 0 clears every flag, and writing 0xFFFF to address 3 clears every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 7 | One-cycle event pulses, bit order as in R2 |
| bus_busy_i | input | 1 | Live bus-busy level |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | Word address: 0 raw, 1 masked, 2 enable-set, 3 enable-clear |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the current address, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The collision of interest is an event pulse and a write-one-to-clear landing on the same flag in the same cycle, together with enable writes racing a flag that is just being set. A directed case drives a pulse and its own clearing write together, and a long random phase with sparse pulses and writes to all four addresses produces many more such overlaps. A bench model that applies the set-wins rule and the one-cycle interrupt delay judges every read and every interrupt sample.

// File: rtl/i2c_isr_pkg.sv
package i2c_isr_pkg;

   localparam int unsigned ISR_EVT_N    = 7;
   localparam int unsigned ISR_DATA_W   = 16;
   localparam int unsigned ISR_BUSY_POS = 12;

   typedef enum logic [1:0] {
      ISR_A_RAW = 2'd0,
      ISR_A_MSK = 2'd1,
      ISR_A_ENS = 2'd2,
      ISR_A_ENC = 2'd3
   } isr_addr_e;

   // Event bit order
   localparam int unsigned EV_NOACK   = 0;
   localparam int unsigned EV_ARBLOST = 1;
   localparam int unsigned EV_DONE    = 2;
   localparam int unsigned EV_TXRDY   = 3;
   localparam int unsigned EV_TXDRN   = 4;
   localparam int unsigned EV_RXRDY   = 5;
   localparam int unsigned EV_RXDRN   = 6;

endpackage

// File: rtl/isr_flag_bank.sv
module isr_flag_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] flags
);

   generate
      if (N < 1) begin : g_bad_n
         $error("isr_flag_bank: N must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic do_clr;
      assign do_clr = clr_stb & clr_mask[i];

      always_ff @(posedge clk) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (evt[i])
            flags[i] <= 1'b1;      // set wins over a same-cycle clear
         else if (do_clr)
            flags[i] <= 1'b0;
      end

      // R2
      evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flags[i]);

      // R3
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_stb && clr_mask[i] && !evt[i]) |=> !flags[i]);

      // R3
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt[i] && !(clr_stb && clr_mask[i])) |=> $stable(flags[i]));
   end

endmodule

// File: rtl/isr_enable_reg.sv
module isr_enable_reg #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [N-1:0] mask,
   output logic [N-1:0] en
);

   logic [N-1:0] en_d;

   always_comb begin
      en_d = en;
      if (set_stb) en_d = en_d | mask;
      if (clr_stb) en_d = en_d & ~mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) en <= '0;
      else        en <= en_d;
   end

   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !clr_stb) |=> ((en & $past(mask)) == $past(mask)));

   // R6
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb) |=> ((en & $past(mask)) == '0));

endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
   parameter int unsigned N          = 7,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   output logic         irq
);

   logic req;
   assign req = |(flags & en);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= req;
         end
         assign irq = irq_q;

         // R9
         irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req |=> irq);

         // R9
         irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req |=> !irq);
      end else begin : g_comb
         assign irq = req;
      end
   endgenerate

endmodule

// File: rtl/i2c_irq_status_regs.sv
module i2c_irq_status_regs
   import i2c_isr_pkg::*;
#(
   parameter int unsigned EVT_N    = ISR_EVT_N,
   parameter int unsigned DATA_W   = ISR_DATA_W,
   parameter int unsigned BUSY_POS = ISR_BUSY_POS,
   parameter bit          IRQ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_N-1:0]  evt_i,
   input  logic              bus_busy_i,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   generate
      if (EVT_N > DATA_W) begin : g_bad_w
         $error("i2c_irq_status_regs: EVT_N exceeds DATA_W");
      end
      if (BUSY_POS < EVT_N || BUSY_POS >= DATA_W) begin : g_bad_busy
         $error("i2c_irq_status_regs: BUSY_POS overlaps flags or is out of range");
      end
   endgenerate

   isr_addr_e   addr;
   logic        wr_status, wr_set, wr_clr;
   logic [EVT_N-1:0] wmask, flags, en;

   assign addr      = isr_addr_e'(reg_addr_i);
   assign wmask     = reg_wdata_i[EVT_N-1:0];
   assign wr_status = reg_wr_i && (addr == ISR_A_RAW || addr == ISR_A_MSK);
   assign wr_set    = reg_wr_i && (addr == ISR_A_ENS);
   assign wr_clr    = reg_wr_i && (addr == ISR_A_ENC);

   isr_flag_bank #(.N(EVT_N)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i),
      .clr_stb  (wr_status),
      .clr_mask (wmask),
      .flags    (flags)
   );

   isr_enable_reg #(.N(EVT_N)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_set),
      .clr_stb (wr_clr),
      .mask    (wmask),
      .en      (en)
   );

   isr_irq_gen #(.N(EVT_N), .REGISTERED(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .en    (en),
      .irq   (irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (addr)
         ISR_A_RAW: begin
            reg_rdata_o[EVT_N-1:0] = flags;
            reg_rdata_o[BUSY_POS]  = bus_busy_i;
         end
         ISR_A_MSK: reg_rdata_o[EVT_N-1:0] = flags & en;
         default:   reg_rdata_o[EVT_N-1:0] = en;
      endcase
   end

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && (evt_i != '0)) |=> ((flags & $past(evt_i)) == $past(evt_i)));

   // R8
   msk_busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ISR_A_MSK) |-> !reg_rdata_o[BUSY_POS]);

endmodule

// File: tb/tb_i2c_irq_status_regs.sv
module tb_i2c_irq_status_regs;

   localparam int N = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] evt_i = '0;
   logic        bus_busy_i = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_addr_i = 2'd0;
   logic [15:0] reg_wdata_i = '0;
   logic [15:0] reg_rdata_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] m_flag = '0;
   logic [N-1:0] m_en   = '0;
   logic         m_irq  = 1'b0;

   always #10 clk = ~clk;

   i2c_irq_status_regs dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_busy_i(bus_busy_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
   );

   function automatic logic [15:0] exp_read(logic [1:0] a, logic busy);
      logic [15:0] r = '0;
      case (a)
         2'd0: begin r[N-1:0] = m_flag; r[12] = busy; end
         2'd1: r[N-1:0] = m_flag & m_en;
         default: r[N-1:0] = m_en;
      endcase
      return r;
   endfunction

   function automatic logic [N-1:0] nxt_flag(logic [N-1:0] f, logic [N-1:0] ev,
                                             logic wr, logic [1:0] a, logic [15:0] d);
      logic [N-1:0] r = f;
      if (wr && a <= 2'd1) r = r & ~d[N-1:0];
      return r | ev;
   endfunction

   function automatic logic [N-1:0] nxt_en(logic [N-1:0] e, logic wr,
                                           logic [1:0] a, logic [15:0] d);
      if (wr && a == 2'd2) return e | d[N-1:0];
      if (wr && a == 2'd3) return e & ~d[N-1:0];
      return e;
   endfunction

   task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called just after a falling edge; returns just after the next falling edge.
   task automatic step(logic [N-1:0] ev, logic busy, logic wr, logic [1:0] a,
                       logic [15:0] d, string tag);
      evt_i = ev; bus_busy_i = busy; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
      #1;
      check(reg_rdata_o, exp_read(a, busy), tag);
      @(posedge clk);
      m_irq  = |(m_flag & m_en);
      m_flag = nxt_flag(m_flag, ev, wr, a, d);
      m_en   = nxt_en(m_en, wr, a, d);
      @(negedge clk);
      evt_i = '0; reg_wr_i = 1'b0;
      check({15'd0, irq_o}, {15'd0, m_irq}, "R9");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_1C2C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check({15'd0, irq_o}, 16'd0, "R1");
      step('0, 0, 0, 2'd0, 16'h0, "R1");
      step('0, 0, 0, 2'd1, 16'h0, "R1");
      step('0, 0, 0, 2'd2, 16'h0, "R1");
      // R2 event latch and hold
      step(7'h01, 0, 0, 2'd0, 16'h0, "R2");
      step('0, 0, 0, 2'd0, 16'h0, "R2");
      step('0, 0, 0, 2'd0, 16'h0, "R2");
      // R7 busy live in raw view, masked view hides flags without enable
      step('0, 1, 0, 2'd0, 16'h0, "R7");
      step('0, 1, 0, 2'd1, 16'h0, "R8");
      // R5 enable set, irq follows
      step('0, 0, 1, 2'd2, 16'h0001, "R5");
      step('0, 0, 0, 2'd3, 16'h0, "R5");
      step('0, 1, 0, 2'd1, 16'h0, "R8");
      // R3 writing zero no effect, then clear
      step('0, 0, 1, 2'd0, 16'h0000, "R3");
      step('0, 0, 1, 2'd1, 16'h0001, "R3");
      step('0, 0, 0, 2'd0, 16'h0, "R3");
      // R4 set wins over same-cycle clear
      step(7'h04, 0, 0, 2'd0, 16'h0, "R4");
      step(7'h04, 0, 1, 2'd0, 16'h0004, "R4");
      step('0, 0, 0, 2'd0, 16'h0, "R4");
      // R10 bulk clears
      step(7'h7F, 0, 1, 2'd2, 16'hFFFF, "R10");
      step('0, 0, 0, 2'd1, 16'h0, "R10");
      step('0, 0, 1, 2'd3, 16'hFFFF, "R10");
      step('0, 0, 0, 2'd3, 16'h0, "R10");
      step('0, 0, 1, 2'd0, 16'hFFFF, "R10");
      step('0, 0, 0, 2'd0, 16'h0, "R10");
      // R6 partial enable clear
      step('0, 0, 1, 2'd2, 16'h007F, "R6");
      step('0, 0, 1, 2'd3, 16'h0005, "R6");
      step('0, 0, 0, 2'd2, 16'h0, "R6");
      // random phase
      for (int k = 0; k < 600; k++) begin
         logic [N-1:0] ev;
         logic [1:0]   a;
         logic [15:0]  d;
         string        tg;
         ev = '0;
         for (int b = 0; b < N; b++) if ($urandom_range(9) == 0) ev[b] = 1'b1;
         a = 2'($urandom_range(3));
         d = 16'($urandom());
         tg = (a == 2'd0) ? "R7" : (a == 2'd1) ? "R8" : "R5";
         step(ev, 1'($urandom_range(1)), ($urandom_range(2) == 0), a, d, tg);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule